// File: doc/BRIEF.md
# Scoreboarded Register File

This block is the general-purpose register file of a scalar, in-order, five-stage pipeline. It holds 32 entries of 32 bits. Each entry also carries a one-bit ready flag that records whether a write to that entry is still in flight. Two combinational read ports return the stored value of an entry together with its ready flag.

When decode issues an instruction, it pulses the claim port with the destination index. This marks the entry as pending. When writeback retires the instruction, it drives the retire port. This stores the result and marks the entry as ready again. Decode also presents up to two source indices, each with its own enable. The block answers with a single `issue_ok` signal, and decode stalls whenever that signal is low.

Entry 0 is hard-wired: it always holds zero and is always ready. Every answer the block gives is computed from the state held at the start of the cycle. A retire therefore releases a stall only on the following cycle. A retire aimed at an entry that is not pending is reported on `retire_err`.

Top module: `sb_regfile`

## Requirements
- R1: After reset every entry reads as value 0 with its ready flag at 1 on both read ports.
- R2: A claim (`claim_en`=1) of entry k, with k≠0, makes entry k read as not ready (flag 0) from the next cycle onward, until it is retired.
- R3: A retire (`ret_en`=1) of entry k, with k≠0, stores `ret_data` into entry k and sets its ready flag. Both take effect from the next cycle.
- R4: Entry 0 always reads as value 0 with its ready flag at 1. Claims and retires aimed at entry 0 change nothing, and a retire to entry 0 never raises `retire_err`.
- R5: `issue_ok` is 1 exactly when every enabled source (`src0_en`, `src1_en`) names a ready entry. A disabled source never causes a stall.
- R6: When a claim and a retire target the same entry k≠0 in the same cycle, the data is stored but the ready flag ends up at 0.
- R7: The read data, the ready flags and `issue_ok` all reflect the state at the start of the cycle. A retire does not release a stall in the cycle in which it is presented.
- R8: `retire_err` is 1, in the same cycle, exactly when `ret_en`=1, `ret_idx`≠0 and the target entry is already ready. The write still stores its data.
- R9: The two read ports are independent, and each can address any entry in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rda_idx | input | 5 | Read port A entry index |
| rda_data | output | 32 | Read port A value |
| rda_rdy | output | 1 | Read port A ready flag |
| rdb_idx | input | 5 | Read port B entry index |
| rdb_data | output | 32 | Read port B value |
| rdb_rdy | output | 1 | Read port B ready flag |
| claim_en | input | 1 | Decode marks a destination entry as pending |
| claim_idx | input | 5 | Destination entry being claimed |
| ret_en | input | 1 | Writeback retire strobe |
| ret_idx | input | 5 | Entry being retired |
| ret_data | input | 32 | Value written on retire |
| src0_en | input | 1 | First source operand is used |
| src0_idx | input | 5 | First source entry |
| src1_en | input | 1 | Second source operand is used |
| src1_idx | input | 5 | Second source entry |
| issue_ok | output | 1 | All enabled sources are ready |
| retire_err | output | 1 | Retire aimed at an entry that is not pending |

## Verification
The hardest situation to reach is a claim and a retire hitting the same non-zero entry in one cycle, while a source or a read port is watching that same entry. The stimulus first claims the entry. It then issues the claim and the retire together and reads the entry's flag and data on the cycle after. A separate case retires an entry while it is being used as a source, and checks that `issue_ok` stays low in that cycle and rises only on the next one. Beyond these directed cases, a long random phase steers retires mostly towards pending entries, so that claim/retire overlaps and stale-state reads happen often.

// File: rtl/sb_regfile_pkg.sv
package sb_regfile_pkg;
  localparam int unsigned SB_ENTRIES_DEF = 32;
  localparam int unsigned SB_WIDTH_DEF   = 32;
endpackage

// File: rtl/sb_ready_track.sv
module sb_ready_track #(
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned IW     = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               claim_en,
  input  logic [IW-1:0]      claim_idx,
  input  logic               ret_en,
  input  logic [IW-1:0]      ret_idx,
  output logic [ENTRIES-1:0] rdy_q
);
  logic [ENTRIES-1:0] rdy_d;
  logic               upd_en;

  assign upd_en = claim_en | ret_en;

  always_comb begin
    rdy_d = rdy_q;
    for (int i = 1; i < ENTRIES; i++) begin
      if (ret_en && ret_idx == IW'(i))     rdy_d[i] = 1'b1;
      if (claim_en && claim_idx == IW'(i)) rdy_d[i] = 1'b0;
    end
    rdy_d[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdy_q <= '1;
    else if (upd_en) rdy_q <= rdy_d;
  end

  // R2: a claim of a non-zero entry leaves it pending
  p_claim_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_en && claim_idx != '0) |=> !rdy_q[$past(claim_idx)]);

  // R3: a retire without a competing claim leaves the entry ready
  p_retire_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_en && !(claim_en && claim_idx == ret_idx)) |=> rdy_q[$past(ret_idx)]);

  // R6: the claim wins over a simultaneous retire of the same entry
  p_claim_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_en && ret_en && claim_idx == ret_idx && ret_idx != '0)
      |=> !rdy_q[$past(ret_idx)]);

  // R4: entry 0 is never pending
  p_zero_ready_r4: assert property (@(posedge clk) disable iff (!rst_n) rdy_q[0]);
endmodule

// File: rtl/sb_data_bank.sv
module sb_data_bank #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned WIDTH   = 32,
  localparam int unsigned IW     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ret_en,
  input  logic [IW-1:0]    ret_idx,
  input  logic [WIDTH-1:0] ret_data,
  input  logic [IW-1:0]    rda_idx,
  output logic [WIDTH-1:0] rda_data,
  input  logic [IW-1:0]    rdb_idx,
  output logic [WIDTH-1:0] rdb_data
);
  logic [WIDTH-1:0] entry_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    if (g == 0) begin : g_zero
      assign entry_q[g] = '0;
    end else begin : g_reg
      logic             wr_en;
      logic [WIDTH-1:0] val_q;
      assign wr_en = ret_en && (ret_idx == IW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     val_q <= '0;
        else if (wr_en) val_q <= ret_data;
      end
      assign entry_q[g] = val_q;
    end
  end

  assign rda_data = entry_q[rda_idx];
  assign rdb_data = entry_q[rdb_idx];

  // R3: a retired value is held in the entry on the next cycle
  p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_en && ret_idx != '0) |=> entry_q[$past(ret_idx)] == $past(ret_data));
endmodule

// File: rtl/sb_issue_check.sv
module sb_issue_check #(
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned IW     = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] rdy_q,
  input  logic               src0_en,
  input  logic [IW-1:0]      src0_idx,
  input  logic               src1_en,
  input  logic [IW-1:0]      src1_idx,
  output logic               issue_ok
);
  logic src0_ok, src1_ok;

  assign src0_ok  = !src0_en || rdy_q[src0_idx];
  assign src1_ok  = !src1_en || rdy_q[src1_idx];
  assign issue_ok = src0_ok && src1_ok;

  // R5: with no source in use, decode is never stalled
  p_no_src_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!src0_en && !src1_en) |-> issue_ok);

  // R4: sources naming entry 0 never stall
  p_zero_src_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((!src0_en || src0_idx == '0) && (!src1_en || src1_idx == '0)) |-> issue_ok);
endmodule

// File: rtl/sb_regfile.sv
module sb_regfile
  import sb_regfile_pkg::*;
#(
  parameter int unsigned ENTRIES = SB_ENTRIES_DEF,
  parameter int unsigned WIDTH   = SB_WIDTH_DEF,
  localparam int unsigned IW     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IW-1:0]    rda_idx,
  output logic [WIDTH-1:0] rda_data,
  output logic             rda_rdy,
  input  logic [IW-1:0]    rdb_idx,
  output logic [WIDTH-1:0] rdb_data,
  output logic             rdb_rdy,
  input  logic             claim_en,
  input  logic [IW-1:0]    claim_idx,
  input  logic             ret_en,
  input  logic [IW-1:0]    ret_idx,
  input  logic [WIDTH-1:0] ret_data,
  input  logic             src0_en,
  input  logic [IW-1:0]    src0_idx,
  input  logic             src1_en,
  input  logic [IW-1:0]    src1_idx,
  output logic             issue_ok,
  output logic             retire_err
);
  logic [ENTRIES-1:0] rdy_q;

  sb_ready_track #(.ENTRIES(ENTRIES)) u_track (
    .clk(clk), .rst_n(rst_n),
    .claim_en(claim_en), .claim_idx(claim_idx),
    .ret_en(ret_en), .ret_idx(ret_idx),
    .rdy_q(rdy_q)
  );

  sb_data_bank #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .ret_en(ret_en), .ret_idx(ret_idx), .ret_data(ret_data),
    .rda_idx(rda_idx), .rda_data(rda_data),
    .rdb_idx(rdb_idx), .rdb_data(rdb_data)
  );

  sb_issue_check #(.ENTRIES(ENTRIES)) u_issue (
    .clk(clk), .rst_n(rst_n), .rdy_q(rdy_q),
    .src0_en(src0_en), .src0_idx(src0_idx),
    .src1_en(src1_en), .src1_idx(src1_idx),
    .issue_ok(issue_ok)
  );

  assign rda_rdy    = rdy_q[rda_idx];
  assign rdb_rdy    = rdy_q[rdb_idx];
  assign retire_err = ret_en && (ret_idx != '0) && rdy_q[ret_idx];

  // R4: entry 0 reads as a ready zero on port A
  p_zero_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rda_idx == '0) |-> (rda_rdy && rda_data == '0));

  // R8: an error is only reported while a retire is presented
  p_err_needs_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
    retire_err |-> (ret_en && ret_idx != '0));

  // R7: a retire alone cannot make a pending entry ready in the same cycle
  p_stale_view_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_en && !rda_rdy && rda_idx == ret_idx) |-> !retire_err);
endmodule

// File: tb/sb_regfile_tb.sv
module sb_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  rda_idx, rdb_idx, claim_idx, ret_idx, src0_idx, src1_idx;
  logic        claim_en, ret_en, src0_en, src1_en;
  logic [31:0] ret_data;
  logic [31:0] rda_data, rdb_data;
  logic        rda_rdy, rdb_rdy, issue_ok, retire_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string phase = "R1";

  logic [31:0] ref_val [N];
  bit          ref_rdy [N];

  sb_regfile u_dut (
    .clk(clk), .rst_n(rst_n),
    .rda_idx(rda_idx), .rda_data(rda_data), .rda_rdy(rda_rdy),
    .rdb_idx(rdb_idx), .rdb_data(rdb_data), .rdb_rdy(rdb_rdy),
    .claim_en(claim_en), .claim_idx(claim_idx),
    .ret_en(ret_en), .ret_idx(ret_idx), .ret_data(ret_data),
    .src0_en(src0_en), .src0_idx(src0_idx),
    .src1_en(src1_en), .src1_idx(src1_idx),
    .issue_ok(issue_ok), .retire_err(retire_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", phase, what, act, exp);
    end
  endtask

  task automatic idle();
    claim_en = 0; ret_en = 0; src0_en = 0; src1_en = 0;
    claim_idx = 0; ret_idx = 0; ret_data = 0; src0_idx = 0; src1_idx = 0;
  endtask

  // compare outputs against the model, then clock and update the model
  task automatic cycle();
    bit exp_ok;
    #1;
    exp_ok = (!src0_en || ref_rdy[src0_idx]) && (!src1_en || ref_rdy[src1_idx]);
    chk("R3 rda_data", rda_data, ref_val[rda_idx]);
    chk("R2 rda_rdy",  32'(rda_rdy), 32'(ref_rdy[rda_idx]));
    chk("R9 rdb_data", rdb_data, ref_val[rdb_idx]);
    chk("R9 rdb_rdy",  32'(rdb_rdy), 32'(ref_rdy[rdb_idx]));
    chk("R5 issue_ok", 32'(issue_ok), 32'(exp_ok));
    chk("R8 retire_err", 32'(retire_err),
        32'(ret_en && ret_idx != 0 && ref_rdy[ret_idx]));
    @(posedge clk);
    if (ret_en && ret_idx != 0) begin
      ref_val[ret_idx] = ret_data;
      ref_rdy[ret_idx] = 1;
    end
    if (claim_en && claim_idx != 0) ref_rdy[claim_idx] = 0;
    @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin ref_val[i] = 0; ref_rdy[i] = 1; end
    idle(); rda_idx = 0; rdb_idx = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    phase = "R1";
    for (int i = 0; i < N; i++) begin
      rda_idx = 5'(i); rdb_idx = 5'(N-1-i);
      cycle();
    end

    phase = "R2";
    claim_en = 1; claim_idx = 5; cycle(); idle();
    rda_idx = 5; src0_en = 1; src0_idx = 5; cycle();
    chk("R2 pending flag", 32'(rda_rdy), 0);

    phase = "R3";
    idle(); ret_en = 1; ret_idx = 5; ret_data = 32'hCAFE_0005; cycle(); idle();
    rda_idx = 5; #1;
    chk("R3 stored value", rda_data, 32'hCAFE_0005);
    chk("R3 ready again", 32'(rda_rdy), 1);
    cycle();

    phase = "R7";
    claim_en = 1; claim_idx = 7; cycle(); idle();
    ret_en = 1; ret_idx = 7; ret_data = 32'h7777; src0_en = 1; src0_idx = 7;
    src1_en = 1; src1_idx = 0; rda_idx = 7; #1;
    chk("R7 stall held same cycle", 32'(issue_ok), 0);
    cycle(); ret_en = 0; #1;
    chk("R7 stall released next cycle", 32'(issue_ok), 1);
    cycle(); idle();

    phase = "R6";
    claim_en = 1; claim_idx = 9; cycle();
    ret_en = 1; ret_idx = 9; ret_data = 32'h9999_0009; cycle(); idle();
    rda_idx = 9; #1;
    chk("R6 claim wins flag", 32'(rda_rdy), 0);
    chk("R6 data stored", rda_data, 32'h9999_0009);
    cycle();
    ret_en = 1; ret_idx = 9; ret_data = 32'h1; cycle(); idle();

    phase = "R4";
    claim_en = 1; claim_idx = 0; ret_en = 1; ret_idx = 0; ret_data = '1;
    #1; chk("R4 no error on entry 0", 32'(retire_err), 0);
    cycle(); idle();
    rda_idx = 0; rdb_idx = 0; src0_en = 1; src0_idx = 0; #1;
    chk("R4 zero value", rda_data, 0);
    chk("R4 zero ready", 32'(rdb_rdy), 1);
    cycle(); idle();

    phase = "R8";
    ret_en = 1; ret_idx = 3; ret_data = 32'h3333; #1;
    chk("R8 error raised", 32'(retire_err), 1);
    cycle(); idle(); rda_idx = 3; #1;
    chk("R8 data still stored", rda_data, 32'h3333);
    cycle();

    phase = "R5";
    claim_en = 1; claim_idx = 12; cycle(); idle();
    src0_en = 0; src0_idx = 12; src1_en = 0; src1_idx = 12; #1;
    chk("R5 disabled sources ignored", 32'(issue_ok), 1);
    cycle();
    src1_en = 1; #1;
    chk("R5 enabled pending source stalls", 32'(issue_ok), 0);
    cycle(); idle();

    phase = "random";
    for (int k = 0; k < 4000; k++) begin
      int unsigned r;
      r = $urandom;
      rda_idx = 5'($urandom); rdb_idx = 5'($urandom);
      src0_en = r[0]; src0_idx = 5'($urandom);
      src1_en = r[1]; src1_idx = 5'($urandom);
      claim_en = (r[4:2] < 3); claim_idx = 5'($urandom);
      ret_idx = 5'($urandom); ret_data = $urandom;
      ret_en = (!ref_rdy[ret_idx] && r[5]) || (r[9:6] == 0);
      cycle();
    end
    idle(); cycle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule